// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block models a flow-through synchronous SRAM whose write data trails its address by exactly one clock. Because of that offset, a read can follow a write, or a write a read, on consecutive edges without an idle cycle on the shared data bus. Each rising edge with the clock enable asserted samples one command: a load, which takes a new address and picks read or write, or a continue, which takes the next address from an external burst counter and keeps the type chosen at the load.

Write data and its byte mask sit in a pending register for one more active edge before they reach the array. Reads merge the array word with the pending write and with the write data arriving on the same edge, byte by byte, so they always return the newest value. The output side gives the read data together with a drive enable for an external tri-state buffer. This enable also depends on an asynchronous active-low output enable.

Top module: `zbt_sram_core`

## Requirements
- R1: On a load edge (`adv_i`=0) the device is selected only when `cs_ni`=0, `cs2_ni`=0 and `cs3_i`=1; otherwise the edge is a deselect and `dq_oe_o` is 0 in the following cycle.
- R2: On a load edge `rnw_i`=1 starts a read and `rnw_i`=0 a write at `addr_i`; on a continue edge (`adv_i`=1) after a selected load, `rnw_i` is ignored, the type from the load is kept and the address is `burst_addr_i`.
- R3: A deselect, and a continue edge that follows a deselect, leave the bus undriven and change no array word.
- R4: Byte lane i is bits [8i+7:8i]; `bwe_ni[i]`=0, sampled with the write address, allows lane i of the data presented on the next active edge to be written, and other lanes keep their value.
- R5: A write with `bwe_ni` all ones changes no array word.
- R6: Read data for an address accepted on an active edge is on `dq_o` with `dq_oe_o`=1 during the following cycle, even when the previous edge was a write.
- R7: A read returns the newest data per byte, including bytes of a write whose data has not yet reached the array or arrives on the same edge.
- R8: With `cke_ni`=1 the edge is ignored: a pending read keeps driving the same data, a pending write keeps the bus undriven and takes its data on the next active edge, and nothing is written.
- R9: `dq_oe_o` is 1 only in a read data cycle with `oe_ni`=0; it follows `oe_ni` without a clock and is 0 during write data cycles.
- R10: After reset the bus is undriven, no burst is active and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high ignores the edge |
| adv_i | input | 1 | 0 loads a new address, 1 continues the burst |
| rnw_i | input | 1 | Cycle type on a load: 1 read, 0 write |
| cs_ni | input | 1 | Primary select, active low |
| cs2_ni | input | 1 | Expansion select, active low |
| cs3_i | input | 1 | Expansion select, active high |
| addr_i | input | AW | Load address |
| burst_addr_i | input | AW | Next burst address from the external counter |
| bwe_ni | input | NB | Byte write enables, active low |
| wdata_i | input | NB*LW | Write data, one active edge after its address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_o | output | NB*LW | Read data |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
A read command is due on the outputs in the cycle after its active edge, and write data is due on the bus one active edge after its address; a stalled edge moves both deadlines back by one. The driver pushes one expected bus state for every edge it drives, including stalls and write cycles, and the monitor takes one entry 5 ns after each rising edge. Each check therefore compares against the state due after that edge. The reference memory takes a write when its data is presented, so every read expectation already holds the newest bytes without copying the pipeline.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_cmd_dec.sv
module zbt_cmd_dec
  import zbt_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  input  logic          rnw_i,
  input  logic          cs_ni,
  input  logic          cs2_ni,
  input  logic          cs3_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] burst_addr_i,
  input  logic [NB-1:0] bwe_ni,
  output op_e           nxt_op_o,
  output logic [AW-1:0] nxt_addr_o,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic [NB-1:0] mask_o
);
  logic          sel;
  logic          act_d, act_q, wr_d, wr_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [NB-1:0] mask_q;

  always_comb begin
    sel        = !cs_ni && !cs2_ni && cs3_i;
    act_d      = act_q;
    wr_d       = wr_q;
    nxt_op_o   = OP_NONE;
    nxt_addr_o = burst_addr_i;
    if (!adv_i) begin
      nxt_addr_o = addr_i;
      act_d      = sel;
      if (sel) begin
        wr_d     = !rnw_i;
        nxt_op_o = rnw_i ? OP_READ : OP_WRITE;
      end
    end else if (act_q) begin
      nxt_op_o = wr_q ? OP_WRITE : OP_READ;  // type fixed at the load
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      mask_q <= '0;
    end else if (en_i) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      op_q   <= nxt_op_o;
      addr_q <= nxt_addr_o;
      mask_q <= (nxt_op_o == OP_WRITE) ? ~bwe_ni : '0;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;

  AST_DESEL_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i && (cs_ni || cs2_ni || !cs3_i)) |=> (op_q == OP_NONE)); // R1
  AST_CONT_KEEPS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && act_q) |=> (op_q == ($past(wr_q) ? OP_WRITE : OP_READ))); // R2
  AST_CONT_AFTER_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && !act_q) |=> (op_q == OP_NONE)); // R3
endmodule

// File: rtl/zbt_wr_reg.sv
module zbt_wr_reg
  import zbt_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] mask_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wv_o,
  output logic [AW-1:0] waddr_o,
  output logic [NB-1:0] wmask_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wv_o    <= 1'b0;
      waddr_o <= '0;
      wmask_o <= '0;
      wdata_o <= '0;
    end else if (en_i) begin
      wv_o    <= (op_i == OP_WRITE) && (|mask_i);
      waddr_o <= addr_i;
      wmask_o <= mask_i;
      wdata_o <= wdata_i;
    end
  end

  AST_ABORT_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_WRITE && mask_i == '0) |=> !wv_o); // R5
  AST_DATA_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_WRITE && |mask_i) |=> (wv_o && wmask_o == $past(mask_i))); // R4
  AST_STALL_HOLDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(wv_o) && $stable(wdata_o) && $stable(waddr_o))); // R8
endmodule

// File: rtl/zbt_mem.sv
module zbt_mem #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [NB-1:0] wmask_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < NB; l++)
        if (wmask_i[l]) mem_q[waddr_i][l*LW +: LW] <= wdata_i[l*LW +: LW];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/zbt_rd_fwd.sv
module zbt_rd_fwd #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic [AW-1:0] raddr_i,
  input  logic [DW-1:0] arr_i,
  input  logic          pend_v_i,
  input  logic [AW-1:0] pend_addr_i,
  input  logic [NB-1:0] pend_mask_i,
  input  logic [DW-1:0] pend_data_i,
  input  logic          new_v_i,
  input  logic [AW-1:0] new_addr_i,
  input  logic [NB-1:0] new_mask_i,
  input  logic [DW-1:0] new_data_i,
  output logic [DW-1:0] data_o
);
  logic pend_hit, new_hit;
  assign pend_hit = pend_v_i && (pend_addr_i == raddr_i);
  assign new_hit  = new_v_i && (new_addr_i == raddr_i);

  // newest source wins per lane: arriving data, then pending register, then array
  for (genvar l = 0; l < NB; l++) begin : g_lane
    always_comb begin
      data_o[l*LW +: LW] = arr_i[l*LW +: LW];
      if (pend_hit && pend_mask_i[l]) data_o[l*LW +: LW] = pend_data_i[l*LW +: LW];
      if (new_hit && new_mask_i[l])   data_o[l*LW +: LW] = new_data_i[l*LW +: LW];
    end
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          adv_i,
  input  logic          rnw_i,
  input  logic          cs_ni,
  input  logic          cs2_ni,
  input  logic          cs3_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] burst_addr_i,
  input  logic [NB-1:0] bwe_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          oe_ni,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic          en;
  op_e           nxt_op, op_q;
  logic [AW-1:0] nxt_addr, addr_q;
  logic [NB-1:0] mask_q;
  logic          wv;
  logic [AW-1:0] waddr;
  logic [NB-1:0] wmask;
  logic [DW-1:0] wdata, arr_rd, fwd_rd, rd_q;

  assign en = !cke_ni;

  zbt_cmd_dec #(.AW(AW), .NB(NB)) u_dec (
    .clk_i, .rst_ni, .en_i(en), .adv_i, .rnw_i, .cs_ni, .cs2_ni, .cs3_i,
    .addr_i, .burst_addr_i, .bwe_ni,
    .nxt_op_o(nxt_op), .nxt_addr_o(nxt_addr),
    .op_o(op_q), .addr_o(addr_q), .mask_o(mask_q)
  );

  zbt_wr_reg #(.AW(AW), .NB(NB), .LW(LW)) u_wr (
    .clk_i, .rst_ni, .en_i(en), .op_i(op_q), .addr_i(addr_q), .mask_i(mask_q),
    .wdata_i, .wv_o(wv), .waddr_o(waddr), .wmask_o(wmask), .wdata_o(wdata)
  );

  zbt_mem #(.AW(AW), .NB(NB), .LW(LW)) u_mem (
    .clk_i, .rst_ni, .we_i(en && wv), .waddr_i(waddr), .wmask_i(wmask),
    .wdata_i(wdata), .raddr_i(nxt_addr), .rdata_o(arr_rd)
  );

  zbt_rd_fwd #(.AW(AW), .NB(NB), .LW(LW)) u_fwd (
    .raddr_i(nxt_addr), .arr_i(arr_rd),
    .pend_v_i(wv), .pend_addr_i(waddr), .pend_mask_i(wmask), .pend_data_i(wdata),
    .new_v_i(op_q == OP_WRITE), .new_addr_i(addr_q), .new_mask_i(mask_q),
    .new_data_i(wdata_i), .data_o(fwd_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rd_q <= '0;
    else if (en && nxt_op == OP_READ)     rd_q <= fwd_rd;
  end

  assign dq_o    = rd_q;
  assign dq_oe_o = (op_q == OP_READ) && !oe_ni;

  AST_HIZ_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_WRITE) |-> !dq_oe_o); // R9
  AST_HIZ_ON_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_NONE) |-> !dq_oe_o); // R3
  AST_STALL_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_ni && op_q == OP_READ) |=> (op_q == OP_READ && $stable(rd_q))); // R8
  AST_READ_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && nxt_op == OP_READ && !oe_ni) |=> (oe_ni || dq_oe_o)); // R6
  AST_NO_WRITE_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(wv)); // R8
endmodule

// File: tb/zbt_sram_core_tb.sv
module zbt_sram_core_tb;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int LW = 8;
  localparam int DW = NB * LW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_ni = 1'b0, adv_i = 1'b0, rnw_i = 1'b1;
  logic          cs_ni = 1'b1, cs2_ni = 1'b0, cs3_i = 1'b1;
  logic [AW-1:0] addr_i = '0, burst_addr_i = '0;
  logic [NB-1:0] bwe_ni = '1;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_ni = 1'b0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  always #10 clk = ~clk;

  zbt_sram_core #(.AW(AW), .NB(NB), .LW(LW)) u_dut (
    .clk_i(clk), .rst_ni, .cke_ni, .adv_i, .rnw_i, .cs_ni, .cs2_ni, .cs3_i,
    .addr_i, .burst_addr_i, .bwe_ni, .wdata_i, .oe_ni, .dq_o, .dq_oe_o
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem [1<<AW];
  int            st_op = 0;  // 0 none, 1 read, 2 write
  logic [AW-1:0] st_addr = '0;
  logic [NB-1:0] st_mask = '0;
  logic [DW-1:0] st_data = '0;
  bit            b_act = 0, b_wr = 0;

  bit            exp_drv_q[$];
  logic [DW-1:0] exp_dat_q[$];
  string         req_q[$];

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic step(input bit stall, input bit adv, input bit rnw, input bit c1n,
                      input bit c2n, input bit c3, input logic [AW-1:0] a,
                      input logic [NB-1:0] bwe, input logic [AW-1:0] ba,
                      input bit oen, input string req);
    logic [DW-1:0] d;
    int op;
    logic [AW-1:0] opa;
    @(negedge clk);
    cke_ni = stall; adv_i = adv; rnw_i = rnw; cs_ni = c1n; cs2_ni = c2n; cs3_i = c3;
    addr_i = a; bwe_ni = bwe; burst_addr_i = ba; oe_ni = oen;
    d = $urandom;
    wdata_i = d;
    if (!stall && st_op == 2)
      for (int l = 0; l < NB; l++)
        if (st_mask[l]) ref_mem[st_addr][l*LW +: LW] = d[l*LW +: LW];
    if (!stall) begin
      op = 0; opa = a;
      if (!adv) begin
        if (!c1n && !c2n && c3) begin b_act = 1; b_wr = !rnw; op = b_wr ? 2 : 1; end
        else b_act = 0;
      end else if (b_act) begin
        op = b_wr ? 2 : 1; opa = ba;
      end
      st_op = op; st_addr = opa;
      st_mask = (op == 2) ? ~bwe : '0;
      if (op == 1) st_data = ref_mem[opa];
    end
    exp_drv_q.push_back(st_op == 1 && !oen);
    exp_dat_q.push_back(st_data);
    req_q.push_back(req);
  endtask

  task automatic ld(input bit rnw, input logic [AW-1:0] a, input logic [NB-1:0] bwe,
                    input string req);
    step(0, 0, rnw, 0, 0, 1, a, bwe, '0, 0, req);
  endtask
  task automatic cont(input bit rnw, input logic [AW-1:0] ba, input string req);
    step(0, 1, rnw, 1, 1, 0, '0, '0, ba, 0, req);
  endtask
  task automatic stall(input string req);
    step(1, 0, 0, 0, 0, 1, '0, '0, '0, 0, req);
  endtask
  task automatic idle(input string req);
    step(0, 0, 1, 1, 0, 1, '0, '1, '0, 0, req);
  endtask

  // monitor: one expected bus state per driven edge
  initial begin
    wait (rst_ni);
    forever begin
      @(posedge clk);
      #5;
      if (exp_drv_q.size() > 0) begin
        bit e_drv;
        logic [DW-1:0] e_dat;
        string r;
        e_drv = exp_drv_q.pop_front();
        e_dat = exp_dat_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (dq_oe_o !== e_drv || (e_drv && dq_o !== e_dat)) begin
          errors++;
          $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                   r, dq_oe_o, dq_o, e_drv, e_dat);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    #35;
    checks++;
    if (dq_oe_o !== 1'b0) begin
      errors++;
      $display("FAIL R10: drive=%0b expected drive=0 in reset", dq_oe_o);
    end
    @(negedge clk); rst_ni = 1'b1;

    ld(1, 4'd3, '1, "R10");          // unwritten word reads zero
    idle("R10");
    // R6 R7: write then read same address back to back
    ld(0, 4'd1, 4'b0000, "R6");
    ld(1, 4'd1, '1, "R6");
    ld(1, 4'd1, '1, "R7");
    ld(1, 4'd1, '1, "R7");
    // R4: single lane write, neighbours keep value
    ld(0, 4'd1, 4'b1011, "R4");
    ld(1, 4'd1, '1, "R4");
    ld(0, 4'd2, 4'b1110, "R4");
    ld(1, 4'd2, '1, "R4");
    // R5: abort
    ld(0, 4'd1, 4'b1111, "R5");
    ld(1, 4'd1, '1, "R5");
    // R1: each enable deselects
    step(0, 0, 1, 1, 0, 1, 4'd1, '1, '0, 0, "R1");
    step(0, 0, 1, 0, 1, 1, 4'd1, '1, '0, 0, "R1");
    step(0, 0, 1, 0, 0, 0, 4'd1, '1, '0, 0, "R1");
    // R3: deselected write and continue after deselect
    step(0, 0, 0, 1, 0, 1, 4'd1, 4'b0000, '0, 0, "R3");
    step(0, 1, 0, 0, 0, 1, 4'd1, 4'b0000, 4'd1, 0, "R3");
    cont(0, 4'd2, "R3");
    ld(1, 4'd1, '1, "R3");
    ld(1, 4'd2, '1, "R3");
    // R2: bursts ignore rnw on continue
    ld(0, 4'd5, 4'b0000, "R2");
    step(0, 1, 1, 1, 1, 0, '0, 4'b0000, 4'd6, 0, "R2");
    ld(1, 4'd5, '1, "R2");
    cont(0, 4'd6, "R2");
    cont(1, 4'd5, "R2");
    // R8: stall during read and during write data
    ld(1, 4'd6, '1, "R8");
    stall("R8");
    stall("R8");
    ld(0, 4'd7, 4'b0000, "R8");
    stall("R8");
    stall("R8");
    ld(1, 4'd7, '1, "R8");
    ld(1, 4'd7, '1, "R8");
    // R9: output enable gating and write data cycles
    step(0, 0, 1, 0, 0, 1, 4'd7, '1, '0, 1, "R9");
    ld(0, 4'd8, 4'b0000, "R9");
    ld(1, 4'd8, '1, "R9");

    // random mix on few addresses to hit forwarding
    for (int n = 0; n < 2000; n++) begin
      int k;
      logic [AW-1:0] ra;
      bit oen;
      k = $urandom_range(0, 9);
      ra = AW'($urandom_range(0, 3));
      oen = ($urandom_range(0, 7) == 0);
      case (k)
        0, 1, 2, 3: step(0, 0, 1, 0, 0, 1, ra, '1, '0, oen, "R7");
        4, 5, 6:    step(0, 0, 0, 0, 0, 1, ra, NB'($urandom), '0, oen, "R7");
        7:          step(0, 1, 1'($urandom), 1, 1, 0, '0, NB'($urandom), ra, oen, "R2");
        8:          step(1, 0, 0, 0, 0, 1, ra, '0, '0, oen, "R8");
        default:    step(0, 0, 1'($urandom), 1'($urandom), 1, 1'($urandom), ra,
                         NB'($urandom), '0, oen, "R1");
      endcase
    end
    for (int i = 0; i < (1 << AW); i++) ld(1, AW'(i), '1, "R7");
    idle("R3");
    repeat (3) @(posedge clk);
    #6;
    summary();
    $finish;
  end
endmodule